// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from page tables held in memory. A directory lookup comes first: it uses the top twelve address bits and the table base that software has programmed. If that entry is valid, it supplies the start of a second-level table, and the middle eight bits choose one entry in it. A valid second-level entry supplies a 4 KB frame number and a 4-bit access-control index. The frame number is joined with the low twelve address bits of the request. The index is passed on unchanged for whatever logic enforces permissions downstream.

A client presents a virtual address through a valid/ready request port. The walker then issues at most two reads on a simple memory port. That port has a request handshake and returns one response word for each request, at any latency. The walker answers with a one-cycle reply that carries the physical address, the index and two fault flags. When translation is switched off, the address passes through unchanged and memory is not touched. A small configuration write port holds the table base and the enable bit.

Top module: `pgwalk_top`

## Requirements
- R1: After synchronous reset the walker accepts requests (`req_ready` high), issues no memory read, gives no reply, and starts with translation disabled and a table base of zero.
- R2: A configuration write to offset 0x050 loads the table base from the full write data. A write to offset 0x020 loads the enable flag from data bit 0. Writes to any other offset change neither value.
- R3: With translation disabled, a request is answered with `rsp_paddr` equal to the virtual address, index 0 and no fault, and no memory read is issued.
- R4: The first read goes to table base + 4 × virtual address bits 31:20.
- R5: A directory entry is usable only when its bits 1:0 equal 2'b01. Any other value ends the walk after one read with `rsp_fault_dir` set, `rsp_paddr` and `rsp_aci` zero, and `rsp_vaddr` equal to the request address.
- R6: The second read goes to {directory entry bits 31:10, ten zero bits} + 4 × virtual address bits 19:12.
- R7: A second-level entry whose bit 1 is clear ends the walk with `rsp_fault_pg` set, `rsp_paddr` and `rsp_aci` zero, and `rsp_vaddr` equal to the request address.
- R8: On success, `rsp_paddr` is {entry bits 31:12, virtual address bits 11:0} and `rsp_aci` is entry bits 7:4.
- R9: Only one walk runs at a time. `req_ready` is low from the cycle after acceptance through the reply cycle. `rsp_valid` lasts exactly one cycle, and `req_ready` is high again in the next cycle.
- R10: A memory read request holds `mem_req_valid` and an unchanged `mem_req_addr` until `mem_req_ready` is seen. The answer may arrive any number of cycles later.
- R11: The two fault flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_aci | output | 4 | Access-control index from the page entry |
| rsp_fault_dir | output | 1 | Directory entry was invalid |
| rsp_fault_pg | output | 1 | Page entry was invalid |
| rsp_vaddr | output | 32 | Virtual address of the walk being answered |

## Verification
If the index slicing or the address arithmetic is wrong, `mem_req_addr` is wrong at the very handshake that issues the read, which is one or two memory transactions into the walk. An error in a validity test or in a state transition shows up one cycle after the matching response word: a spurious or missing fault flag, or a read count other than zero, one or two. Address-assembly slips appear in the reply word itself. A stuck or skipped state leaves `req_ready` low, or lets it rise before the reply. A missing reply halts the walk within the per-walk wait limit.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int AW         = 32;
    localparam int DIR_W      = 12;
    localparam int PG_W       = 8;
    localparam int OFS_W      = AW - DIR_W - PG_W;
    localparam int ENT_SH     = 2;
    localparam int TBL_LSB    = 10;
    localparam int ACI_W      = 4;
    localparam int ACI_LSB    = 4;
    localparam int PG_VLD_BIT = 1;
    localparam int CFG_AW     = 12;

    localparam logic [CFG_AW-1:0] CFG_BASE_OFS = 12'h050;
    localparam logic [CFG_AW-1:0] CFG_EN_OFS   = 12'h020;
    localparam logic [1:0]        DIR_OK_CODE  = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PG_REQ,
        ST_PG_WAIT,
        ST_REPLY
    } walk_st_e;

    typedef struct packed {
        logic [AW-1:0]    paddr;
        logic [ACI_W-1:0] aci;
        logic             flt_dir;
        logic             flt_pg;
    } walk_res_t;

    function automatic logic [AW-1:0] dir_slot(input logic [AW-1:0] va);
        return AW'(va[AW-1 -: DIR_W]) << ENT_SH;
    endfunction

    function automatic logic [AW-1:0] pg_slot(input logic [AW-1:0] va);
        return AW'(va[OFS_W +: PG_W]) << ENT_SH;
    endfunction

    function automatic logic [OFS_W-1:0] pg_offset(input logic [AW-1:0] va);
        return va[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/pgwalk_cfg.sv
module pgwalk_cfg
    import pgwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [AW-1:0]     wdata,
    output logic [AW-1:0]     tbl_base,
    output logic              xlat_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_base <= '0;
            xlat_en  <= 1'b0;
        end else if (we) begin
            if (addr == CFG_BASE_OFS) tbl_base <= wdata;
            if (addr == CFG_EN_OFS)   xlat_en  <= wdata[0];
        end
    end

endmodule

// File: rtl/pgwalk_decode.sv
module pgwalk_decode
    import pgwalk_pkg::*;
(
    input  logic [AW-1:0]    entry,
    output logic             dir_ok,
    output logic [AW-1:0]    next_tbl,
    output logic             pg_ok,
    output logic [AW-1:0]    frame,
    output logic [ACI_W-1:0] aci
);

    always_comb begin
        dir_ok   = (entry[1:0] == DIR_OK_CODE);
        next_tbl = {entry[AW-1:TBL_LSB], {TBL_LSB{1'b0}}};
        pg_ok    = entry[PG_VLD_BIT];
        frame    = {entry[AW-1:OFS_W], {OFS_W{1'b0}}};
        aci      = entry[ACI_LSB +: ACI_W];
    end

endmodule

// File: rtl/pgwalk_walker.sv
module pgwalk_walker
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xlat_en,
    input  logic [AW-1:0]    tbl_base,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_vaddr,
    output logic             req_ready,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic             dir_ok,
    input  logic [AW-1:0]    next_tbl,
    input  logic             pg_ok,
    input  logic [AW-1:0]    frame,
    input  logic [ACI_W-1:0] aci,
    output logic             rsp_valid,
    output walk_res_t        rsp_res,
    output logic [AW-1:0]    rsp_vaddr
);

    walk_st_e  st;
    logic [AW-1:0] va_q;
    logic [AW-1:0] addr_q;
    walk_res_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            res_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q  <= req_vaddr;
                        res_q <= '0;
                        if (xlat_en) begin
                            addr_q <= tbl_base + dir_slot(req_vaddr);
                            st     <= ST_DIR_REQ;
                        end else begin
                            res_q.paddr <= req_vaddr;
                            st          <= ST_REPLY;
                        end
                    end
                end
                ST_DIR_REQ: if (mem_req_ready) st <= ST_DIR_WAIT;
                ST_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (dir_ok) begin
                            addr_q <= next_tbl + pg_slot(va_q);
                            st     <= ST_PG_REQ;
                        end else begin
                            res_q.flt_dir <= 1'b1;
                            st            <= ST_REPLY;
                        end
                    end
                end
                ST_PG_REQ: if (mem_req_ready) st <= ST_PG_WAIT;
                ST_PG_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (pg_ok) begin
                            res_q.paddr <= frame | AW'(pg_offset(va_q));
                            res_q.aci   <= aci;
                        end else begin
                            res_q.flt_pg <= 1'b1;
                        end
                        st <= ST_REPLY;
                    end
                end
                ST_REPLY: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_DIR_REQ) || (st == ST_PG_REQ);
        mem_req_addr  = addr_q;
        rsp_valid     = (st == ST_REPLY);
        rsp_res       = res_q;
        rsp_vaddr     = va_q;
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [AW-1:0]     mem_rsp_data,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic [ACI_W-1:0]  rsp_aci,
    output logic              rsp_fault_dir,
    output logic              rsp_fault_pg,
    output logic [AW-1:0]     rsp_vaddr
);

    logic [AW-1:0]    tbl_base;
    logic             xlat_en;
    logic             dir_ok, pg_ok;
    logic [AW-1:0]    next_tbl, frame;
    logic [ACI_W-1:0] ent_aci;
    walk_res_t        res;

    pgwalk_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .tbl_base (tbl_base),
        .xlat_en  (xlat_en)
    );

    pgwalk_decode u_dec (
        .entry    (mem_rsp_data),
        .dir_ok   (dir_ok),
        .next_tbl (next_tbl),
        .pg_ok    (pg_ok),
        .frame    (frame),
        .aci      (ent_aci)
    );

    pgwalk_walker u_walk (
        .clk           (clk),
        .rst           (rst),
        .xlat_en       (xlat_en),
        .tbl_base      (tbl_base),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .dir_ok        (dir_ok),
        .next_tbl      (next_tbl),
        .pg_ok         (pg_ok),
        .frame         (frame),
        .aci           (ent_aci),
        .rsp_valid     (rsp_valid),
        .rsp_res       (res),
        .rsp_vaddr     (rsp_vaddr)
    );

    assign rsp_paddr     = res.paddr;
    assign rsp_aci       = res.aci;
    assign rsp_fault_dir = res.flt_dir & rsp_valid;
    assign rsp_fault_pg  = res.flt_pg  & rsp_valid;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [3:0]  rsp_aci,
    input logic        rsp_fault_dir,
    input logic        rsp_fault_pg
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_req_valid && !rsp_valid));

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_fault_dir || rsp_fault_pg)) |-> (rsp_paddr == 32'd0 && rsp_aci == 4'd0));

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    assert_reply_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fault_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_fault_dir, rsp_fault_pg}));

endmodule

bind pgwalk_top pgwalk_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_aci       (rsp_aci),
    .rsp_fault_dir (rsp_fault_dir),
    .rsp_fault_pg  (rsp_fault_pg)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        cfg_we;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_aci;
    logic        rsp_fault_dir, rsp_fault_pg;
    logic [31:0] rsp_vaddr;

    pgwalk_top u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_aci(rsp_aci),
        .rsp_fault_dir(rsp_fault_dir), .rsp_fault_pg(rsp_fault_pg),
        .rsp_vaddr(rsp_vaddr)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [logic [31:0]];
    int          rd_cnt;
    logic [31:0] rd_addr [2];
    bit          pend;
    int          lat;
    logic [31:0] pend_data;
    bit          stalled;
    logic [31:0] stall_addr;

    logic [31:0] sh_base;
    bit          sh_en;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: random ready stalls and random response latency (R10).
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        pend = 0; lat = 0; stalled = 0; rd_cnt = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pend = 0;
                end else begin
                    lat--;
                end
            end
            if (stalled && mem_req_valid)
                chk(mem_req_addr == stall_addr, "R10 address held while stalled", mem_req_addr, stall_addr);
            mem_req_ready = (($urandom % 4) != 0) && !pend;
            if (mem_req_valid && mem_req_ready) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
                pend_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'hDEAD_0000;
                lat  = $urandom % 3;
                pend = 1;
                stalled = 0;
            end else if (mem_req_valid) begin
                stalled = 1;
                stall_addr = mem_req_addr;
            end else begin
                stalled = 0;
            end
        end
    end

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 12'h050) sh_base = d;
        if (a == 12'h020) sh_en = d[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] dte, input logic [31:0] pte);
        logic [31:0] a_dir, a_pg, e_pa;
        logic [3:0]  e_aci;
        bit          e_f1, e_f2, busy_err;
        int          e_rd, waited;
        a_dir = sh_base + {18'd0, va[31:20], 2'b00};
        a_pg  = {dte[31:10], 10'd0} + {22'd0, va[19:12], 2'b00};
        mem[a_dir] = dte;
        mem[a_pg]  = pte;
        e_f1 = 0; e_f2 = 0; e_aci = 0; e_pa = 0;
        if (!sh_en) begin
            e_pa = va; e_rd = 0;
        end else if (dte[1:0] != 2'b01) begin
            e_f1 = 1; e_rd = 1;
        end else if (!pte[1]) begin
            e_f2 = 1; e_rd = 2;
        end else begin
            e_pa = {pte[31:12], va[11:0]}; e_aci = pte[7:4]; e_rd = 2;
        end

        @(negedge clk);
        chk(req_ready, "R9 ready when idle", req_ready, 1);
        rd_cnt = 0;
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0; busy_err = 0;
        while (!rsp_valid && waited < 300) begin
            if (req_ready) busy_err = 1;
            @(negedge clk);
            waited++;
        end
        if (waited >= 300) begin
            chk(0, "watchdog: no reply", waited, 0);
            return;
        end
        chk(!busy_err && !req_ready, "R9 busy while walking", busy_err, 0);
        if (!sh_en) chk(rsp_paddr == e_pa && rd_cnt == 0, "R3 bypass", {rsp_paddr, 32'(rd_cnt)}, {e_pa, 32'd0});
        else        chk(rsp_paddr == e_pa, "R8 physical address", rsp_paddr, e_pa);
        chk(rsp_aci == e_aci, "R8 access index", rsp_aci, e_aci);
        chk(rsp_fault_dir == e_f1, "R5 directory fault", rsp_fault_dir, e_f1);
        chk(rsp_fault_pg == e_f2, "R7 page fault", rsp_fault_pg, e_f2);
        chk(!(rsp_fault_dir && rsp_fault_pg), "R11 faults exclusive", {rsp_fault_dir, rsp_fault_pg}, 0);
        chk(rsp_vaddr == va, "R5/R7 reported address", rsp_vaddr, va);
        chk(rd_cnt == e_rd, "R4/R6 read count", rd_cnt, e_rd);
        if (e_rd >= 1) chk(rd_addr[0] == a_dir, "R4 directory address", rd_addr[0], a_dir);
        if (e_rd == 2) chk(rd_addr[1] == a_pg, "R6 page entry address", rd_addr[1], a_pg);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 one-cycle reply", {rsp_valid, req_ready}, 2'b01);
    endtask

    function automatic logic [31:0] mk_dte(input logic [31:0] pt, input int mode);
        logic [1:0] attr;
        case (mode)
            0: attr = 2'b00;
            1: attr = 2'b11;
            2: attr = 2'b10;
            default: attr = 2'b01;
        endcase
        return {pt[31:10], 8'($urandom), attr};
    endfunction

    function automatic logic [31:0] mk_pte(input bit vld);
        logic [31:0] p;
        p = $urandom;
        p[1] = vld;
        return p;
    endfunction

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        req_valid = 0; req_vaddr = 0;
        sh_base = 0; sh_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset state",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);

        // R1/R3: enable resets to zero, so the first walks bypass.
        for (int i = 0; i < 3; i++) walk($urandom, 32'h0000_0001, 32'h0000_0002);

        // R2: program base and enable, then write neighbours that must not matter.
        cfg_wr(12'h050, 32'h8123_4000);
        cfg_wr(12'h020, 32'h0000_0001);
        cfg_wr(12'h054, 32'hFFFF_FFFF);
        cfg_wr(12'h024, 32'h0000_0000);
        cfg_wr(12'h021, 32'h0000_0000);
        sh_en = 1; sh_base = 32'h8123_4000;
        walk(32'h0030_0ABC, mk_dte(32'h1234_5400, 3), 32'hCAFE_B0A2); // R2 still enabled, R8

        // Directed corners.
        walk(32'h0000_0000, mk_dte(32'h7000_0000, 3), 32'hABCD_E0F2);   // R8 lowest address
        walk(32'hFFFF_FFFF, mk_dte(32'h7FFF_FC00, 3), 32'h1111_1F32);   // R4/R6 top indices
        walk(32'h1234_5678, mk_dte(32'h2000_0000, 0), 32'h0);           // R5 attr 00
        walk(32'h1234_5678, mk_dte(32'h2000_0000, 1), 32'h0);           // R5 attr 11
        walk(32'h1234_5678, mk_dte(32'h2000_0000, 2), 32'h0);           // R5 attr 10
        walk(32'h8765_4321, mk_dte(32'h3000_0400, 3), 32'hFFFF_FFFD);   // R7 only bit 1 clear

        // Random mix.
        for (int i = 0; i < 60; i++) begin
            logic [31:0] pt;
            pt = $urandom & 32'h7FFF_FC00;
            walk($urandom, mk_dte(pt, $urandom % 8), mk_pte(($urandom % 6) != 0));
        end

        // R2: move the base (R4 follows it), including base zero.
        cfg_wr(12'h050, 32'h0000_0000);
        walk(32'h0000_0123, mk_dte(32'h7000_0000, 3), 32'h5555_5052);
        cfg_wr(12'h050, 32'h8FFF_C000);
        for (int i = 0; i < 10; i++)
            walk($urandom, mk_dte($urandom & 32'h7FFF_FC00, 3), mk_pte(1));

        // R3: switch translation off again.
        cfg_wr(12'h020, 32'h0000_0002);
        for (int i = 0; i < 3; i++) walk($urandom, 32'h0000_0001, 32'h0000_0002);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule